// File: doc/BRIEF.md
# Legacy Prefix Scanner

The scanner takes an instruction byte stream, one byte per cycle, over a valid/ready input. It gathers legacy prefix bytes into sticky flags and follows the two-byte escape. It decides which prefix acts as the mandatory prefix and classifies a small set of opcodes. For each instruction it returns one descriptor on a valid/ready output. The descriptor carries the prefix flags, the effective mandatory prefix, the opcode map, the opcode byte, a class code, the byte length and a length-fault flag.

The mandatory prefix is chosen by priority, not by arrival order. A repeat-class prefix (F2/F3) takes the slot over the operand-size prefix (66). Byte 9B is never folded into a following instruction: it is a complete one-byte instruction with a descriptor of its own. The scanner works through only as much of the ModRM byte as it needs to close the opcodes it recognises.

Top module: `prefix_scan`

## Requirements
- R1: An input byte is consumed on a clock edge where in_valid_i and in_ready_o are both high. in_ready_o is low while a descriptor is pending. A pending descriptor holds out_valid_o and every descriptor field steady until out_ready_i is high, and it is released on that edge.
- R2: The recognised prefixes are F0, F2, F3, 2E, 36, 3E, 26, 64, 65, 66 and 67, accepted in any order. Each one sets a sticky bit of out_flags_o at these positions: F0=bit0, F2=bit1, F3=bit2, 2E=bit3, 36=bit4, 3E=bit5, 26=bit6, 64=bit7, 65=bit8, 66=bit9, 67=bit10.
- R3: Byte 9B is a complete instruction: class 1, opcode 9B, map 0, and a length equal to the number of prefixes before it plus one. The stream 9B 9B D9 30 yields three descriptors.
- R4: Byte 0F sets out_map_o to 1, and the byte that follows is reported as the opcode.
- R5: out_mand_o is encoded as 0 none, 1 for 66, 2 for F3 and 3 for F2. When F2 or F3 is present it overrides 66. When both F2 and F3 are present, the one seen last wins.
- R6: A two-byte opcode 12 with a valid memory ModRM gets class 3 (64-bit duplicate load) when out_mand_o is 3. It gets class 4 (low-quadword double load) when out_mand_o is 1. It gets class 0 otherwise.
- R7: A one-byte opcode D9 whose ModRM reg field is 6 and whose ModRM is a valid memory form gets class 2 (no-wait FPU environment store), with opcode D9 and a length of prefixes plus two.
- R8: A valid memory ModRM has mod=00 and r/m other than 100 and 101. Any other ModRM, or a D9 reg field other than 6, gives class 0, and the instruction ends on the ModRM byte.
- R9: Any other opcode byte in either map gives class 0, with that byte as the opcode, and the instruction ends on it.
- R10: A byte consumed while 15 bytes are already held is discarded. It produces a descriptor with out_fault_o=1, length 15, class 0 and opcode 00.
- R11: After reset, out_valid_o is 0 and in_ready_o is 1. After each descriptor is released, the flags, the mandatory choice, the map and the length all start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Instruction stream byte |
| in_ready_o | output | 1 | Scanner can take a byte |
| out_valid_o | output | 1 | Descriptor valid |
| out_ready_i | input | 1 | Descriptor consumer ready |
| out_flags_o | output | 11 | Sticky prefix flags |
| out_mand_o | output | 2 | Effective mandatory prefix |
| out_map_o | output | 1 | 1 for the two-byte opcode map |
| out_opcode_o | output | 8 | Opcode byte |
| out_class_o | output | 3 | Class code |
| out_len_o | output | 4 | Instruction length in bytes |
| out_fault_o | output | 1 | Length fault |

## Verification
The length fault is the hardest case to reach, because only an unbroken run of prefixes can hold 15 bytes without ending an instruction. The bench sends fourteen operand-size prefixes plus a wait byte to land exactly on the limit. It then sends fifteen prefixes followed by a sixteenth byte to trip the fault. After the fault it sends a lone wait byte, which shows that the discarded byte leaves nothing behind. The conflicting repeat-prefix cases use both arrival orders of F2 and F3, each combined with 66, so the last-seen rule and the override of 66 are visible in out_mand_o.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  localparam int unsigned PFX_N = 11;

  typedef enum logic [1:0] {
    MND_NONE  = 2'd0,
    MND_OSZ   = 2'd1,
    MND_REP   = 2'd2,
    MND_REPNE = 2'd3
  } mand_e;

  typedef enum logic [2:0] {
    CLS_UNSUP    = 3'd0,
    CLS_WAIT     = 3'd1,
    CLS_FPENV_ST = 3'd2,
    CLS_DUP64    = 3'd3,
    CLS_LOQ_DBL  = 3'd4
  } cls_e;

  localparam int unsigned PX_REPNE = 1;
  localparam int unsigned PX_REP   = 2;
  localparam int unsigned PX_OSZ   = 9;

  localparam logic [7:0] OP_WAIT = 8'h9B;
  localparam logic [7:0] OP_ESC  = 8'h0F;
  localparam logic [7:0] OP_FPU  = 8'hD9;
  localparam logic [7:0] OP_LDQ  = 8'h12;

  function automatic logic [7:0] pfx_code(int unsigned idx);
    case (idx)
      0:       return 8'hF0;
      1:       return 8'hF2;
      2:       return 8'hF3;
      3:       return 8'h2E;
      4:       return 8'h36;
      5:       return 8'h3E;
      6:       return 8'h26;
      7:       return 8'h64;
      8:       return 8'h65;
      9:       return 8'h66;
      default: return 8'h67;
    endcase
  endfunction
endpackage

// File: rtl/pscan_pfx_dec.sv
module pscan_pfx_dec
  import pscan_pkg::*;
(
  input  logic [7:0]       byte_i,
  output logic [PFX_N-1:0] hit_o
);
  for (genvar g = 0; g < PFX_N; g++) begin : g_cmp
    assign hit_o[g] = (byte_i == pfx_code(g));
  end
endmodule

// File: rtl/pscan_mand.sv
module pscan_mand
  import pscan_pkg::*;
(
  input  logic  osz_i,
  input  logic  repne_i,
  input  logic  rep_i,
  input  logic  last_repne_i,
  output mand_e mand_o
);
  always_comb begin
    if (repne_i || rep_i) mand_o = last_repne_i ? MND_REPNE : MND_REP;
    else if (osz_i)       mand_o = MND_OSZ;
    else                  mand_o = MND_NONE;
  end
endmodule

// File: rtl/pscan_classify.sv
module pscan_classify
  import pscan_pkg::*;
(
  input  logic       map_i,
  input  logic [7:0] op_i,
  input  logic [7:0] modrm_i,
  input  mand_e      mand_i,
  output cls_e       cls_o
);
  logic       mem_ok;
  logic [1:0] mod_f;
  logic [2:0] reg_f, rm_f;

  assign mod_f  = modrm_i[7:6];
  assign reg_f  = modrm_i[5:3];
  assign rm_f   = modrm_i[2:0];
  assign mem_ok = (mod_f == 2'b00) && (rm_f != 3'b100) && (rm_f != 3'b101);

  always_comb begin
    cls_o = CLS_UNSUP;
    if (mem_ok) begin
      if (!map_i && op_i == OP_FPU && reg_f == 3'd6) begin
        cls_o = CLS_FPENV_ST;
      end else if (map_i && op_i == OP_LDQ) begin
        if (mand_i == MND_REPNE)    cls_o = CLS_DUP64;
        else if (mand_i == MND_OSZ) cls_o = CLS_LOQ_DBL;
      end
    end
  end
endmodule

// File: rtl/prefix_scan.sv
module prefix_scan
  import pscan_pkg::*;
#(
  parameter int unsigned MAX_LEN = 15,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_byte_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [10:0]      out_flags_o,
  output logic [1:0]       out_mand_o,
  output logic             out_map_o,
  output logic [7:0]       out_opcode_o,
  output logic [2:0]       out_class_o,
  output logic [LEN_W-1:0] out_len_o,
  output logic             out_fault_o
);
  typedef enum logic [1:0] {ST_PFX, ST_ESC, ST_MRM, ST_OUT} st_e;

  st_e              st_q, st_d;
  logic [PFX_N-1:0] flags_q, flags_d, pfx_hit;
  logic             last_repne_q, last_repne_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             map_q, map_d;
  logic [7:0]       op_q, op_d;
  logic             acc, overlen, emit, e_fault;
  logic [7:0]       e_op;
  cls_e             e_cls, mrm_cls;
  mand_e            mand;

  logic [PFX_N-1:0] d_flags_q;
  logic [1:0]       d_mand_q;
  logic             d_map_q, d_fault_q;
  logic [7:0]       d_op_q;
  logic [2:0]       d_cls_q;
  logic [LEN_W-1:0] d_len_q;

  pscan_pfx_dec u_pfx_dec (.byte_i(in_byte_i), .hit_o(pfx_hit));

  pscan_mand u_mand (
    .osz_i       (flags_q[PX_OSZ]),
    .repne_i     (flags_q[PX_REPNE]),
    .rep_i       (flags_q[PX_REP]),
    .last_repne_i(last_repne_q),
    .mand_o      (mand)
  );

  pscan_classify u_cls (
    .map_i  (map_q),
    .op_i   (op_q),
    .modrm_i(in_byte_i),
    .mand_i (mand),
    .cls_o  (mrm_cls)
  );

  assign in_ready_o = (st_q != ST_OUT);
  assign acc        = in_valid_i && in_ready_o;
  assign overlen    = (cnt_q == LEN_W'(MAX_LEN));

  always_comb begin
    st_d         = st_q;
    flags_d      = flags_q;
    last_repne_d = last_repne_q;
    cnt_d        = cnt_q;
    map_d        = map_q;
    op_d         = op_q;
    emit         = 1'b0;
    e_fault      = 1'b0;
    e_op         = in_byte_i;
    e_cls        = CLS_UNSUP;
    if (st_q == ST_OUT) begin
      if (out_ready_i) begin
        st_d         = ST_PFX;
        flags_d      = '0;
        last_repne_d = 1'b0;
        cnt_d        = '0;
        map_d        = 1'b0;
        op_d         = '0;
      end
    end else if (acc) begin
      cnt_d = cnt_q + 1'b1;
      if (overlen) begin
        // byte beyond the length limit is dropped
        emit    = 1'b1;
        e_fault = 1'b1;
        e_op    = '0;
        cnt_d   = cnt_q;
      end else begin
        case (st_q)
          ST_PFX: begin
            if (|pfx_hit) begin
              flags_d = flags_q | pfx_hit;
              if (pfx_hit[PX_REPNE])    last_repne_d = 1'b1;
              else if (pfx_hit[PX_REP]) last_repne_d = 1'b0;
            end else if (in_byte_i == OP_WAIT) begin
              emit  = 1'b1;
              e_cls = CLS_WAIT;
            end else if (in_byte_i == OP_ESC) begin
              map_d = 1'b1;
              st_d  = ST_ESC;
            end else if (in_byte_i == OP_FPU) begin
              op_d = in_byte_i;
              st_d = ST_MRM;
            end else begin
              emit = 1'b1;
            end
          end
          ST_ESC: begin
            op_d = in_byte_i;
            if (in_byte_i == OP_LDQ) st_d = ST_MRM;
            else                     emit = 1'b1;
          end
          default: begin
            emit  = 1'b1;
            e_op  = op_q;
            e_cls = mrm_cls;
          end
        endcase
      end
      if (emit) st_d = ST_OUT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_PFX;
      flags_q      <= '0;
      last_repne_q <= 1'b0;
      cnt_q        <= '0;
      map_q        <= 1'b0;
      op_q         <= '0;
    end else begin
      st_q         <= st_d;
      flags_q      <= flags_d;
      last_repne_q <= last_repne_d;
      cnt_q        <= cnt_d;
      map_q        <= map_d;
      op_q         <= op_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_flags_q <= '0;
      d_mand_q  <= '0;
      d_map_q   <= 1'b0;
      d_op_q    <= '0;
      d_cls_q   <= '0;
      d_len_q   <= '0;
      d_fault_q <= 1'b0;
    end else if (emit) begin
      d_flags_q <= flags_q;
      d_mand_q  <= mand;
      d_map_q   <= map_q;
      d_op_q    <= e_op;
      d_cls_q   <= e_cls;
      d_len_q   <= cnt_d;
      d_fault_q <= e_fault;
    end
  end

  assign out_valid_o  = (st_q == ST_OUT);
  assign out_flags_o  = d_flags_q;
  assign out_mand_o   = d_mand_q;
  assign out_map_o    = d_map_q;
  assign out_opcode_o = d_op_q;
  assign out_class_o  = d_cls_q;
  assign out_len_o    = d_len_q;
  assign out_fault_o  = d_fault_q;
endmodule

// File: rtl/prefix_scan_chk.sv
module prefix_scan_chk #(
  parameter int unsigned MAX_LEN = 15,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [10:0]      out_flags_o,
  input logic [1:0]       out_mand_o,
  input logic             out_map_o,
  input logic [7:0]       out_opcode_o,
  input logic [2:0]       out_class_o,
  input logic [LEN_W-1:0] out_len_o,
  input logic             out_fault_o
);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_flags_o) && $stable(out_mand_o)
      && $stable(out_map_o) && $stable(out_opcode_o) && $stable(out_class_o)
      && $stable(out_len_o) && $stable(out_fault_o));

  assert_no_take_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> !out_valid_o);

  assert_wait_op_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_class_o == 3'd1 |-> out_opcode_o == 8'h9B && !out_map_o);

  assert_mand_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_flags_o[1] || out_flags_o[2]) |-> out_mand_o[1]);

  assert_dup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_class_o == 3'd3 |-> out_mand_o == 2'd3 && out_map_o && out_opcode_o == 8'h12);

  assert_fpenv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_class_o == 3'd2 |-> out_opcode_o == 8'hD9 && !out_map_o);

  assert_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_len_o != '0 && out_len_o <= LEN_W'(MAX_LEN)
      && (!out_fault_o || out_len_o == LEN_W'(MAX_LEN)));
endmodule

bind prefix_scan prefix_scan_chk #(.MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/test_prefix_scan.sv
module test_prefix_scan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_byte_i = '0;
  logic        in_ready_o, out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [10:0] out_flags_o;
  logic [1:0]  out_mand_o;
  logic        out_map_o, out_fault_o;
  logic [7:0]  out_opcode_o;
  logic [2:0]  out_class_o;
  logic [3:0]  out_len_o;

  int errors = 0;
  int checks = 0;
  logic [29:0] cap_q[$];

  always #10 clk_i = ~clk_i;

  prefix_scan i_prefix_scan (.*);

  always @(negedge clk_i) begin
    #2;
    if (out_valid_o && out_ready_i)
      cap_q.push_back({out_fault_o, out_len_o, out_class_o, out_opcode_o,
                       out_map_o, out_mand_o, out_flags_o});
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_byte_i  = b;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic expect_desc(input string tag, input logic [10:0] fl, input logic [1:0] md,
                             input logic mp, input logic [7:0] op, input logic [2:0] cl,
                             input logic [3:0] ln, input logic ft);
    logic [29:0] d;
    int w = 0;
    while (cap_q.size() == 0 && w < 50) begin
      @(negedge clk_i);
      w++;
    end
    if (cap_q.size() == 0) begin
      check({tag, " descriptor present"}, 0, 1);
    end else begin
      d = cap_q.pop_front();
      check({tag, " flags"}, 32'(d[10:0]), 32'(fl));
      check({tag, " mand"},  32'(d[12:11]), 32'(md));
      check({tag, " map"},   32'(d[13]), 32'(mp));
      check({tag, " opcode"},32'(d[21:14]), 32'(op));
      check({tag, " class"}, 32'(d[24:22]), 32'(cl));
      check({tag, " len"},   32'(d[28:25]), 32'(ln));
      check({tag, " fault"}, 32'(d[29]), 32'(ft));
    end
  endtask

  task automatic t_reset();
    check("R11 reset out_valid", 32'(out_valid_o), 0);
    check("R11 reset in_ready", 32'(in_ready_o), 1);
  endtask

  task automatic t_wait_stream();
    send_byte(8'h9B);
    expect_desc("R3 wait 1", 11'h0, 2'd0, 1'b0, 8'h9B, 3'd1, 4'd1, 1'b0);
    send_byte(8'h9B);
    expect_desc("R3 wait 2", 11'h0, 2'd0, 1'b0, 8'h9B, 3'd1, 4'd1, 1'b0);
    send_byte(8'hD9); send_byte(8'h30);
    expect_desc("R7 fpenv store", 11'h0, 2'd0, 1'b0, 8'hD9, 3'd2, 4'd2, 1'b0);
  endtask

  task automatic t_load_forms();
    send_byte(8'hF2); send_byte(8'h66); send_byte(8'h0F); send_byte(8'h12); send_byte(8'h00);
    expect_desc("R6 R5 F2 over 66", 11'h202, 2'd3, 1'b1, 8'h12, 3'd3, 4'd5, 1'b0);
    send_byte(8'h66); send_byte(8'h0F); send_byte(8'h12); send_byte(8'h00);
    expect_desc("R6 R4 lowq load", 11'h200, 2'd1, 1'b1, 8'h12, 3'd4, 4'd4, 1'b0);
    send_byte(8'h0F); send_byte(8'h12); send_byte(8'h07);
    expect_desc("R6 no mandatory", 11'h0, 2'd0, 1'b1, 8'h12, 3'd0, 4'd3, 1'b0);
  endtask

  task automatic t_rep_order();
    send_byte(8'hF2); send_byte(8'hF3); send_byte(8'h66);
    send_byte(8'h0F); send_byte(8'h12); send_byte(8'h00);
    expect_desc("R5 F3 last", 11'h206, 2'd2, 1'b1, 8'h12, 3'd0, 4'd6, 1'b0);
    send_byte(8'hF3); send_byte(8'hF2); send_byte(8'h0F); send_byte(8'h12); send_byte(8'h08);
    expect_desc("R5 F2 last", 11'h006, 2'd3, 1'b1, 8'h12, 3'd3, 4'd5, 1'b0);
  endtask

  task automatic t_prefix_flags();
    send_byte(8'h67); send_byte(8'hF0); send_byte(8'h2E); send_byte(8'h36);
    send_byte(8'h3E); send_byte(8'h26); send_byte(8'h64); send_byte(8'h65);
    send_byte(8'h9B);
    expect_desc("R2 mixed prefixes", 11'h5F9, 2'd0, 1'b0, 8'h9B, 3'd1, 4'd9, 1'b0);
    send_byte(8'h9B);
    expect_desc("R11 cleared after descriptor", 11'h0, 2'd0, 1'b0, 8'h9B, 3'd1, 4'd1, 1'b0);
  endtask

  task automatic t_bad_modrm();
    send_byte(8'hD9); send_byte(8'h34);
    expect_desc("R8 rm 100", 11'h0, 2'd0, 1'b0, 8'hD9, 3'd0, 4'd2, 1'b0);
    send_byte(8'hD9); send_byte(8'h70);
    expect_desc("R8 mod 01", 11'h0, 2'd0, 1'b0, 8'hD9, 3'd0, 4'd2, 1'b0);
    send_byte(8'hD9); send_byte(8'h28);
    expect_desc("R8 reg 5", 11'h0, 2'd0, 1'b0, 8'hD9, 3'd0, 4'd2, 1'b0);
    send_byte(8'h66); send_byte(8'h0F); send_byte(8'h12); send_byte(8'h05);
    expect_desc("R8 rm 101", 11'h200, 2'd1, 1'b1, 8'h12, 3'd0, 4'd4, 1'b0);
  endtask

  task automatic t_unsupported();
    send_byte(8'h90);
    expect_desc("R9 one-byte", 11'h0, 2'd0, 1'b0, 8'h90, 3'd0, 4'd1, 1'b0);
    send_byte(8'h0F); send_byte(8'h05);
    expect_desc("R9 R4 two-byte", 11'h0, 2'd0, 1'b1, 8'h05, 3'd0, 4'd2, 1'b0);
  endtask

  task automatic t_length();
    for (int i = 0; i < 14; i++) send_byte(8'h66);
    send_byte(8'h9B);
    expect_desc("R10 at limit", 11'h200, 2'd1, 1'b0, 8'h9B, 3'd1, 4'd15, 1'b0);
    for (int i = 0; i < 15; i++) send_byte(8'h66);
    send_byte(8'h9B);
    expect_desc("R10 over limit", 11'h200, 2'd1, 1'b0, 8'h00, 3'd0, 4'd15, 1'b1);
    send_byte(8'h9B);
    expect_desc("R10 after fault", 11'h0, 2'd0, 1'b0, 8'h9B, 3'd1, 4'd1, 1'b0);
  endtask

  task automatic t_backpressure();
    @(negedge clk_i);
    out_ready_i = 1'b0;
    send_byte(8'h64); send_byte(8'h9B);
    repeat (4) @(negedge clk_i);
    #1;
    check("R1 held valid", 32'(out_valid_o), 1);
    check("R1 not ready", 32'(in_ready_o), 0);
    check("R1 held class", 32'(out_class_o), 1);
    check("R1 held len", 32'(out_len_o), 2);
    check("R1 nothing taken", 32'(cap_q.size()), 0);
    @(negedge clk_i);
    out_ready_i = 1'b1;
    expect_desc("R1 released", 11'h080, 2'd0, 1'b0, 8'h9B, 3'd1, 4'd2, 1'b0);
    @(negedge clk_i);
    #1;
    check("R1 valid dropped", 32'(out_valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    t_wait_stream();
    t_load_forms();
    t_rep_order();
    t_prefix_flags();
    t_bad_modrm();
    t_unsupported();
    t_length();
    t_backpressure();
    repeat (4) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule